// File: doc/BRIEF.md
# Sync Period Meter

This block measures the period of a horizontal and a vertical sync signal and presents both results as byte-wide register pairs. The vertical period is counted in units of 2^VDIV_LOG2 clock cycles (64 by default). The horizontal period is taken as the raw clock count across eight consecutive lines. That gives one eighth of a clock period per count unit, so software divides eight times the clock frequency by the count to get the line rate. Both counters are 12 bits wide and stop at 0xFFF.

Every vertical rising edge after the first one, and every vertical timeout, latches both results together and raises a one-cycle event. A timeout happens after 4096 vertical units with no vertical edge, which is the lowest frame rate the counter can resolve. Each result is split into a high and a low byte. Bit 7 of each high byte carries the polarity flag of its sync, as sampled on the latching edge. The sync and polarity inputs are expected to be already synchronous to the clock. The results are held registers that software reads at any time, so there is no back-pressure: a reader that misses an event simply sees the next set of results.

Top module: `sync_period_meter`

## Requirements
- R1: On a vertical rising edge, the latched vertical count is floor(K / 2^VDIV_LOG2), where K is the number of clock edges since the previous vertical rising edge or timeout.
- R2: The horizontal result is the clock count across eight consecutive horizontal periods (8 × line period in clocks). The event latches the most recent complete eight-line measurement.
- R3: A horizontal measurement that reaches 0xFFF saturates there and is reported as 0xFFF. This covers line periods of 512 clocks and longer.
- R4: After 4096 vertical units with no vertical rising edge, an event is raised with a vertical count of 0xFFF, and vertical counting restarts from zero on that edge.
- R5: Each high byte is laid out as {polarity, 3'b000, count[11:8]} and each low byte is count[7:0]. The polarity bit holds the value the polarity input had at the latching edge.
- R6: The four result bytes change only on the clock edge that raises the event. They hold their value between events.
- R7: The event is a single-cycle pulse. It is registered on the first clock edge that samples the vertical sync high after it was low.
- R8: The first vertical rising edge after reset only starts the measurement and raises no event.
- R9: During and right after reset, all result bytes and the event are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Normalized horizontal sync, active high |
| vsync_in | input | 1 | Normalized vertical sync, active high |
| hpol_in | input | 1 | Detected horizontal polarity flag |
| vpol_in | input | 1 | Detected vertical polarity flag |
| hper_hi | output | 8 | Horizontal polarity and count bits 11:8 |
| hper_lo | output | 8 | Horizontal count bits 7:0 |
| vper_hi | output | 8 | Vertical polarity and count bits 11:8 |
| vper_lo | output | 8 | Vertical count bits 7:0 |
| meas_evt | output | 1 | One-cycle pulse when new results are latched |

## Verification
The assertions assume that vertical sync is low during reset and stays high for at least one clock per pulse. Under that assumption, an event with no rising edge in the cycle before it can only be a timeout. They also assume that the polarity inputs are synchronous, so the previous cycle's sample is the latched one. The stimulus drives every input on the falling clock edge. It holds vertical sync low through reset and makes each vertical pulse two clocks wide. It keeps each frame shorter than the timeout, except in the one scenario that waits for the timeout on purpose.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CNT_W = 12;
  typedef logic [CNT_W-1:0] count_t;
  localparam count_t CNT_MAX = '1;

  // high byte: polarity, three zero bits, count[11:8]; low byte: count[7:0]
  function automatic logic [15:0] pack_pair(input logic pol, input count_t c);
    return {pol, 3'b000, c[11:8], c[7:0]};
  endfunction
endpackage

// File: rtl/spm_rise_det.sv
module spm_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/spm_sat_count.sv
module spm_sat_count
  import spm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   inc,
  output count_t count,
  output count_t next_val,
  output logic   at_max
);
  assign at_max   = (count == CNT_MAX);
  assign next_val = (inc && !at_max) ? count + count_t'(1) : count;

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= next_val;
  end
endmodule

// File: rtl/spm_hmeas.sv
module spm_hmeas
  import spm_pkg::*;
#(
  parameter int LINES_LOG2 = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise,
  output count_t hold
);
  logic                  armed;
  logic [LINES_LOG2-1:0] line;
  logic                  last_line;
  logic                  capture;
  logic                  restart;
  count_t                cnt, cnt_next;
  logic                  cnt_max;

  assign last_line = (line == '1);
  assign capture   = rise && armed && last_line;
  assign restart   = rise && (!armed || last_line);

  spm_sat_count u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (restart),
    .inc      (1'b1),
    .count    (cnt),
    .next_val (cnt_next),
    .at_max   (cnt_max)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      line  <= '0;
      hold  <= '0;
    end else begin
      if (rise) armed <= 1'b1;
      if (restart)   line <= '0;
      else if (rise) line <= line + 1'b1;
      if (capture)      hold <= cnt_next;
      else if (cnt_max) hold <= CNT_MAX;
    end
  end
endmodule

// File: rtl/spm_vmeas.sv
module spm_vmeas
  import spm_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rise,
  output logic   evt_req,
  output count_t value
);
  logic [DIV_LOG2-1:0] pre;
  logic                tick;
  logic                armed;
  logic                timeout;
  logic                start;
  count_t              cnt, cnt_next;
  logic                cnt_max;

  assign tick    = &pre;
  assign timeout = tick && cnt_max;
  assign start   = rise || timeout;

  spm_sat_count u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .inc      (tick),
    .count    (cnt),
    .next_val (cnt_next),
    .at_max   (cnt_max)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      armed <= 1'b0;
    end else begin
      if (start) pre <= '0;
      else       pre <= pre + 1'b1;
      if (rise) armed <= 1'b1;
    end
  end

  assign evt_req = (rise && armed) || timeout;
  assign value   = (timeout && !rise) ? CNT_MAX : cnt_next;
endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter
  import spm_pkg::*;
#(
  parameter int VDIV_LOG2   = 6,
  parameter int HLINES_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic       hpol_in,
  input  logic       vpol_in,
  output logic [7:0] hper_hi,
  output logic [7:0] hper_lo,
  output logic [7:0] vper_hi,
  output logic [7:0] vper_lo,
  output logic       meas_evt
);
  logic        h_rise, v_rise, v_evt;
  count_t      h_hold, v_val;
  logic [15:0] h_reg, v_reg;

  spm_rise_det u_hedge (.clk(clk), .rst_n(rst_n), .din(hsync_in), .rise(h_rise));
  spm_rise_det u_vedge (.clk(clk), .rst_n(rst_n), .din(vsync_in), .rise(v_rise));

  spm_hmeas #(.LINES_LOG2(HLINES_LOG2)) u_h (
    .clk(clk), .rst_n(rst_n), .rise(h_rise), .hold(h_hold)
  );

  spm_vmeas #(.DIV_LOG2(VDIV_LOG2)) u_v (
    .clk(clk), .rst_n(rst_n), .rise(v_rise), .evt_req(v_evt), .value(v_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_reg    <= '0;
      v_reg    <= '0;
      meas_evt <= 1'b0;
    end else begin
      meas_evt <= v_evt;
      if (v_evt) begin
        h_reg <= pack_pair(hpol_in, h_hold);
        v_reg <= pack_pair(vpol_in, v_val);
      end
    end
  end

  assign hper_hi = h_reg[15:8];
  assign hper_lo = h_reg[7:0];
  assign vper_hi = v_reg[15:8];
  assign vper_lo = v_reg[7:0];
endmodule

// File: rtl/spm_checker.sv
module spm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync_in,
  input logic       hpol_in,
  input logic       vpol_in,
  input logic [7:0] hper_hi,
  input logic [7:0] hper_lo,
  input logic [7:0] vper_hi,
  input logic [7:0] vper_lo,
  input logic       meas_evt
);
  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_evt |-> $stable({hper_hi, hper_lo, vper_hi, vper_lo}));

  assert_evt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    meas_evt |=> !meas_evt);

  assert_pol_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_evt |-> (hper_hi[7] == $past(hpol_in)) && (vper_hi[7] == $past(vpol_in)));

  assert_timeout_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_evt && !($past(vsync_in) && !$past(vsync_in, 2))) |->
      ({vper_hi[3:0], vper_lo} == 12'hFFF));
endmodule

bind sync_period_meter spm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hpol_in(hpol_in),
  .vpol_in(vpol_in), .hper_hi(hper_hi), .hper_lo(hper_lo),
  .vper_hi(vper_hi), .vper_lo(vper_lo), .meas_evt(meas_evt)
);

// File: tb/sim_sync_period_meter.sv
module sim_sync_period_meter;
  localparam int DIV_LOG2 = 2;
  localparam int DIV      = 1 << DIV_LOG2;
  localparam int TMO      = 4096 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, hpol_in = 1'b0, vpol_in = 1'b0;
  logic [7:0] hper_hi, hper_lo, vper_hi, vper_lo;
  logic meas_evt;

  always #5 clk = ~clk;

  sync_period_meter #(.VDIV_LOG2(DIV_LOG2), .HLINES_LOG2(3)) u0 (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hpol_in(hpol_in), .vpol_in(vpol_in), .hper_hi(hper_hi), .hper_lo(hper_lo),
    .vper_hi(vper_hi), .vper_lo(vper_lo), .meas_evt(meas_evt)
  );

  typedef struct {
    logic [7:0] hh, hl, vh, vl;
    string      tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  int cyc = 0, anchor = 0, ph = 0, evt_seen = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int hexp();
    return (8 * ph > 4095) ? 4095 : 8 * ph;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input int hv, input int vv, input string tag);
    exp_t e;
    e.hh = {hpol_in, 3'b000, 4'(hv >> 8)};
    e.hl = 8'(hv);
    e.vh = {vpol_in, 3'b000, 4'(vv >> 8)};
    e.vl = 8'(vv);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one vertical pulse; expect_evt=0 only for the arming edge
  task automatic v_pulse(input bit expect_evt, input string tag);
    int e;
    @(negedge clk);
    e = cyc + 1;
    if (expect_evt) push(hexp(), (e - anchor) / DIV, tag);
    vsync_in = 1'b1;
    anchor = e;
    wait_cyc(2);
    vsync_in = 1'b0;
  endtask

  // wait through a vertical timeout
  task automatic v_timeout();
    push(hexp(), 4095, "R4");
    anchor = anchor + TMO;
    while (cyc < anchor + 5) @(negedge clk);
  endtask

  // horizontal sync generator
  initial begin
    forever begin
      if (ph == 0) begin
        @(negedge clk);
      end else begin
        hsync_in = 1'b1;
        wait_cyc(2);
        hsync_in = 1'b0;
        wait_cyc(ph - 2);
      end
    end
  end

  // monitor / scoreboard
  logic [31:0] last_regs = '0;
  bit stable_ok = 1'b1, prev_evt = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (meas_evt) begin
        evt_seen++;
        check("R7 pulse", {31'd0, prev_evt}, 32'd0);
        check("R6 hold between events", {31'd0, stable_ok}, 32'd1);
        stable_ok = 1'b1;
        if (q.size() == 0) begin
          check("R8 unexpected event", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " H result R2"}, {16'd0, hper_hi, hper_lo}, {16'd0, e.hh, e.hl});
          check({e.tag, " V result R1"}, {16'd0, vper_hi, vper_lo}, {16'd0, e.vh, e.vl});
        end
      end else if ({hper_hi, hper_lo, vper_hi, vper_lo} != last_regs) begin
        stable_ok = 1'b0;
      end
      last_regs = {hper_hi, hper_lo, vper_hi, vper_lo};
      prev_evt  = meas_evt;
    end
  end

  initial begin
    wait_cyc(4);
    check("R9 reset regs", {hper_hi, hper_lo, vper_hi, vper_lo}, 32'd0);
    check("R9 reset evt", {31'd0, meas_evt}, 32'd0);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1 R2 R5: line period 100 -> H 800, arming edge raises nothing (R8)
    ph = 100; hpol_in = 1'b1; vpol_in = 1'b0;
    v_pulse(1'b0, "arm");
    wait_cyc(40);
    check("R8 no event after first edge", evt_seen, 0);
    wait_cyc(2000);
    v_pulse(1'b1, "R1 R2 R5 ph100");
    wait_cyc(777);
    v_pulse(1'b1, "R1 ph100 second");

    ph = 37; hpol_in = 1'b0; vpol_in = 1'b1;
    wait_cyc(18 * 37 + 700);
    v_pulse(1'b1, "R2 R5 ph37");
    wait_cyc(3001);
    v_pulse(1'b1, "R1 ph37");

    ph = 511; hpol_in = 1'b1; vpol_in = 1'b1;
    wait_cyc(18 * 511 + 700);
    v_pulse(1'b1, "R3 ph511 edge");

    ph = 512;
    wait_cyc(18 * 512 + 700);
    v_pulse(1'b1, "R3 ph512 sat");

    ph = 600; hpol_in = 1'b0; vpol_in = 1'b0;
    wait_cyc(18 * 600 + 700);
    v_pulse(1'b1, "R3 ph600 sat");

    ph = 50;
    v_timeout();
    wait_cyc(101);
    v_pulse(1'b1, "R4 restart");
    wait_cyc(10);
    v_pulse(1'b1, "R1 short frame");
    wait_cyc(30);

    check("R1 all events seen", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule